// File: doc/BRIEF.md
# Oversampled Two-Wire Register Target with Page-Wrapped Writes

This block is the serial target end of a small register map. It runs entirely on the system clock. SCL and SDA are brought in as raw pin samples, and SDA is pulled low through an open-drain enable. The block recognises bus start, repeated start and stop conditions and compares the 7-bit device address with a fixed six-bit prefix plus one strap input. It keeps an 8-bit memory pointer and turns bus traffic into single-cycle write strobes and read requests for a register back end. That back end owns the storage and returns read data one cycle after it is asked.

A write transfer uses its first byte after the device address to load the pointer. Each further byte is written to the pointer location, and the pointer then advances inside its aligned four-byte page: it wraps to the page's first address instead of crossing into the next page. A read transfer carries no pointer byte. It streams data from wherever the pointer stands, advancing by one per byte across page boundaries and from FFh back to 00h, for as long as the master acknowledges. A busy input from the back end makes the block refuse its own address, so a master can poll until a slow commit has finished.

The control state machine has eight states:

- IDLE waits for a start.
- ADDR shifts in the device address.
- PTR shifts in the pointer byte.
- WDATA shifts in write data.
- ACK drives the acknowledge bit.
- RDATA shifts read data out.
- RACK samples the master's acknowledge.
- IGNORE waits out foreign or finished traffic.

Transitions:

- Any state goes to ADDR on a start and to IDLE on a stop.
- ADDR goes to ACK on a match and to IGNORE on a mismatch or while busy.
- PTR and WDATA go to ACK after eight bits.
- ACK goes on, at the falling clock that ends it, to PTR after a write address, to WDATA after a pointer or data byte, and to RDATA after a read address.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA on a master ACK and to IGNORE on a NACK.

Top module: `serial_reg_target`

## Requirements
- R1: After reset sda_oe is 0 and wr_stb, rd_req and stop_pulse are all 0.
- R2: The address byte is {111010, strap, rw}, i.e. E8h (write) or E9h (read) with strap 0, and EAh/EBh with strap 1. On a match the block pulls SDA low during the ninth bit.
- R3: On an address mismatch the block drives nothing and strobes nothing until the next start condition.
- R4: While busy is 1 at the end of the address byte, the address is not acknowledged and the transfer is ignored.
- R5: In a write transfer the byte after the address loads the pointer. Each later byte gives one single-cycle wr_stb carrying the pointer as wr_addr and the byte as wr_data. Every byte of a matched write is acknowledged.
- R6: After each written byte the pointer advances only in its two low bits, so writing past address 4k+3 continues at 4k.
- R7: A read transfer returns data from the current pointer, which advances by one after every byte, crossing page boundaries and wrapping from FFh to 00h. A pointer left by an earlier transfer is used as is.
- R8: The master's ACK (0) in the ninth bit of a read byte requests the next byte. After a NACK (1), SDA is released for the rest of the transfer.
- R9: Bits are taken on the filtered SCL rising edge, most significant bit first. The block changes what it drives on SDA only while filtered SCL is low.
- R10: A start or stop that arrives in the middle of a byte discards the partial byte: no strobe, and the pointer is unchanged.
- R11: Every stop condition produces exactly one single-cycle stop_pulse.
- R12: A one-clock pulse on SDA while SCL is high is filtered out and neither alters the data nor creates a start or stop.
- R13: rd_req is a single-cycle pulse, and rd_data is taken in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock pin sample |
| sda_in | input | 1 | Raw serial data pin sample |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap | input | 1 | Lowest device address bit |
| busy | input | 1 | Back end busy; address is refused |
| wr_stb | output | 1 | Single-cycle write strobe |
| wr_addr | output | 8 | Register address for the write |
| wr_data | output | 8 | Register data for the write |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | 8 | Register address for the read |
| rd_data | input | 8 | Read data, valid the cycle after rd_req |
| stop_pulse | output | 1 | Single-cycle pulse at each stop |

## Verification
The hardest conditions to reach from the pins are those that depend on bus phase rather than on data: a start or stop landing inside a byte, a pointer left mid-page by a previous read, and a one-clock SDA spike while SCL is high. Directed sequences drive a partial byte followed by a stop or a repeated start, then read without a pointer byte so that the pointer the block kept is exposed. A spike is injected inside the high phase of a data bit. Seeded random writes of one to six bytes at random pointers force page wraps. Random reads, with and without a pointer-setting write, run across page ends and the FFh boundary, and a reference byte map in the bench checks every result.

// File: rtl/sregt_pkg.sv
package sregt_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/sregt_line_filter.sv
module sregt_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    // Bus idles high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q) begin
                dout <= 1'b1;
            end else if (~|hist_q) begin
                dout <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sregt_cond_detect.sv
module sregt_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    // Conditions are SDA edges while SCL stays high on both samples.
    assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/serial_reg_target.sv
module serial_reg_target
    import sregt_pkg::*;
#(
    parameter int         PAGE_BITS   = 2,
    parameter logic [5:0] DEV_HI      = 6'b111010,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic        strap,
    input  logic        busy,
    output logic        wr_stb,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        rd_req,
    output logic [7:0]  rd_addr,
    input  logic [7:0]  rd_data,
    output logic        stop_pulse
);

    localparam int N_LINES = 2;
    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

    // ---------------- line conditioning ----------------
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               scl_f;
    logic               sda_f;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        sregt_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    logic scl_rise;
    logic scl_fall;
    logic start_c;
    logic stop_c;

    sregt_cond_detect u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_c (start_c),
        .stop_c  (stop_c)
    );

    // ---------------- control state ----------------
    tgt_state_e             state;
    tgt_state_e             state_nx;
    tgt_state_e             ack_next;
    logic [BIT_CNT_W-1:0]   cnt;
    byte_t                  shreg;
    byte_t                  tx_q;
    byte_t                  ptr;
    logic                   rd_pend;
    logic                   mack_q;
    logic                   byte_full;
    logic                   addr_hit;
    logic [PAGE_BITS-1:0]   page_lo_nx;
    byte_t                  page_next;

    assign byte_full  = (cnt == FULL_CNT);
    assign addr_hit   = (shreg[BYTE_W-1:1] == {DEV_HI, strap}) && !busy;
    assign page_lo_nx = ptr[PAGE_BITS-1:0] + PAGE_BITS'(1);
    assign page_next  = {ptr[BYTE_W-1:PAGE_BITS], page_lo_nx};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        if (stop_c) begin
            state_nx = ST_IDLE;
        end else if (start_c) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_ADDR: begin
                    if (scl_fall && byte_full) begin
                        state_nx = addr_hit ? ST_ACK : ST_IGNORE;
                    end
                end
                ST_PTR, ST_WDATA: begin
                    if (scl_fall && byte_full) begin
                        state_nx = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state_nx = ack_next;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall && byte_full) begin
                        state_nx = ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        state_nx = mack_q ? ST_RDATA : ST_IGNORE;
                    end
                end
            endcase
        end
    end

    // Datapath, pointer and back-end strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_next   <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            tx_q       <= '0;
            ptr        <= '0;
            rd_pend    <= 1'b0;
            mack_q     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            rd_req     <= 1'b0;
            rd_addr    <= '0;
            stop_pulse <= 1'b0;
        end else begin
            wr_stb     <= 1'b0;
            rd_req     <= 1'b0;
            rd_pend    <= rd_req;
            stop_pulse <= stop_c;
            if (rd_pend) begin
                tx_q <= rd_data;
            end
            if (start_c || stop_c) begin
                cnt <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_f};
                            cnt   <= cnt + BIT_CNT_W'(1);
                        end else if (scl_fall && byte_full) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    if (shreg[0]) begin
                                        rd_req   <= 1'b1;
                                        rd_addr  <= ptr;
                                        ack_next <= ST_RDATA;
                                    end else begin
                                        ack_next <= ST_PTR;
                                    end
                                end
                            end else if (state == ST_PTR) begin
                                ptr      <= shreg;
                                ack_next <= ST_WDATA;
                            end else begin
                                wr_stb   <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= shreg;
                                ptr      <= page_next;
                                ack_next <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + BIT_CNT_W'(1);
                        end else if (scl_fall) begin
                            if (byte_full) begin
                                cnt <= '0;
                                ptr <= ptr + BYTE_W'(1);
                            end else begin
                                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                            if (!sda_f) begin
                                rd_req  <= 1'b1;
                                rd_addr <= ptr;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Bus output
    always_comb begin
        unique case (state)
            ST_ACK:   sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~tx_q[BYTE_W-1];
            default:  sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/sregt_checker.sv
module sregt_checker
    import sregt_pkg::*;
#(
    parameter int PAGE_BITS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] wr_addr,
    input logic       rd_req,
    input logic       stop_pulse,
    input logic       scl_f,
    input logic       start_c,
    input logic       stop_c,
    input tgt_state_e state
);

    logic [7:0]           prev_addr;
    logic                 prev_ok;
    logic [PAGE_BITS-1:0] exp_lo;
    logic [7:0]           exp_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_addr <= '0;
            prev_ok   <= 1'b0;
        end else if (start_c || stop_c) begin
            prev_ok <= 1'b0;
        end else if (wr_stb) begin
            prev_addr <= wr_addr;
            prev_ok   <= 1'b1;
        end
    end

    assign exp_lo   = prev_addr[PAGE_BITS-1:0] + PAGE_BITS'(1);
    assign exp_addr = {prev_addr[7:PAGE_BITS], exp_lo};

    // R3: once ignoring, only a start or stop leaves that state
    a_r3_ignore_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |=> (state == ST_IGNORE || state == ST_ADDR || state == ST_IDLE));

    // R4: the address acknowledge is never entered while busy
    a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ADDR && state == ST_ACK) |-> !$past(busy));

    // R5: write strobe lasts one cycle
    a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6: successive writes of one transfer stay in one page
    a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && prev_ok) |-> wr_addr == exp_addr);

    // R13: read request lasts one cycle
    a_r13_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R9: the driven SDA level changes only while SCL is low (or at a bus condition)
    a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_f || $past(start_c) || $past(stop_c)));

    // R11: stop pulse lasts one cycle
    a_r11_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

endmodule

bind serial_reg_target sregt_checker #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .rd_req    (rd_req),
    .stop_pulse(stop_pulse),
    .scl_f     (scl_f),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .state     (state)
);

// File: tb/serial_reg_target_bench.sv
module serial_reg_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       strap = 1'b0;
    logic       busy  = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic       wr_stb;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       rd_req;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       stop_pulse;

    logic [7:0] bmem    [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;
    int         wr_cnt   = 0;
    int         stop_cnt = 0;
    int         n_chk    = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    assign sda_line = m_sda & ~sda_oe;
    assign rd_data  = bmem[rd_addr];

    serial_reg_target u_serial_reg_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .strap     (strap),
        .busy      (busy),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .stop_pulse(stop_pulse)
    );

    // Back-end register model fed by the strobes
    always @(posedge clk) begin
        if (wr_stb) begin
            bmem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (stop_pulse) stop_cnt <= stop_cnt + 1;
    end

    function automatic logic [7:0] dev_byte(input logic s, input logic rw);
        return {6'b111010, s, rw};
    endfunction

    function automatic logic [7:0] page_step(input logic [7:0] p);
        return {p[7:2], p[1:0] + 2'd1};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic bus_bit(input logic b, input bit glitch, output logic r);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(Q/2);
        if (glitch) begin
            m_sda = 1'b0; tick(1);
            m_sda = b;    tick(Q/2 - 1);
        end else begin
            tick(Q/2);
        end
        r = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], glitch && (i == 4), r);
        bus_bit(1'b1, 1'b0, r);
        acked = !r;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, 1'b0, r);
            d[i] = r;
        end
        bus_bit(nack, 1'b0, r);
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < 256; i++) if (bmem[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    // Write transfer; all bytes are sent even if the address is refused.
    task automatic do_write(input logic [7:0] dev, input logic [7:0] p, input int n,
                            input bit exp_ack, input string req);
        bit a;
        logic [7:0] d;
        int w0 = wr_cnt;
        int s0 = stop_cnt;
        bus_start();
        send_byte(dev, 1'b0, a);
        check(a == exp_ack, req, int'(a), int'(exp_ack));
        send_byte(p, 1'b0, a);
        check(a == exp_ack, "R5 ptr ack", int'(a), int'(exp_ack));
        if (exp_ack) exp_ptr = p;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, 1'b0, a);
            check(a == exp_ack, "R5 data ack", int'(a), int'(exp_ack));
            if (exp_ack) begin
                exp_mem[exp_ptr] = d;
                exp_ptr = page_step(exp_ptr);
            end
        end
        bus_stop();
        tick(4);
        check(wr_cnt - w0 == (exp_ack ? n : 0), "R5 strobe count", wr_cnt - w0, exp_ack ? n : 0);
        check(stop_cnt - s0 == 1, "R11 stop pulse", stop_cnt - s0, 1);
        check(mem_mismatch() == 0, "R6 register contents", mem_mismatch(), 0);
    endtask

    task automatic do_read(input bit set_ptr, input logic [7:0] p, input int n, input string req);
        bit a;
        logic [7:0] d;
        bus_start();
        if (set_ptr) begin
            send_byte(dev_byte(strap, 1'b0), 1'b0, a);
            check(a, "R2 write address ack", int'(a), 1);
            send_byte(p, 1'b0, a);
            exp_ptr = p;
            bus_start();
        end
        send_byte(dev_byte(strap, 1'b1), 1'b0, a);
        check(a, "R2 read address ack", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            check(d == exp_mem[exp_ptr], req, int'(d), int'(exp_mem[exp_ptr]));
            exp_ptr = exp_ptr + 8'd1;
        end
        tick(Q);
        check(sda_oe == 1'b0, "R8 released after NACK", int'(sda_oe), 0);
        bus_stop();
        tick(4);
    endtask

    initial begin
        bit a;
        logic [7:0] d;
        int w0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) begin
            bmem[i]    = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        tick(5);
        check(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        check(wr_stb == 1'b0 && rd_req == 1'b0 && stop_pulse == 1'b0, "R1 strobes",
              int'({wr_stb, rd_req, stop_pulse}), 0);
        rst_n = 1'b1;
        tick(10);

        // Basic write and readback (R2, R5, R7)
        do_write(8'hE8, 8'h10, 1, 1'b1, "R2 E8 ack");
        do_read(1'b1, 8'h10, 1, "R7,R9 readback");

        // Page wrap: six bytes from 06h land in 06,07,04,05,06,07 (R6)
        do_write(8'hE8, 8'h06, 6, 1'b1, "R2 ack");
        do_read(1'b1, 8'h04, 4, "R6 wrapped page read");

        // Read crossing a page, then continue from the kept pointer (R7)
        do_read(1'b1, 8'h03, 3, "R7 page crossing read");
        do_read(1'b0, 8'h00, 2, "R7 kept pointer read");

        // Pointer wrap FFh -> 00h (R7)
        do_read(1'b1, 8'hFF, 2, "R7 FF to 00 read");

        // Foreign address: no ack, nothing written (R3)
        do_write(8'hD0, 8'h20, 2, 1'b0, "R3 foreign address");

        // Busy refuses the address, then accepted (R4)
        busy = 1'b1;
        do_write(8'hE8, 8'h30, 2, 1'b0, "R4 busy refuses");
        busy = 1'b0;
        do_write(8'hE8, 8'h30, 2, 1'b1, "R4 idle accepts");

        // Strap selects the low address bit (R2)
        strap = 1'b1;
        do_write(8'hEA, 8'h40, 1, 1'b1, "R2 strap 1 EA");
        do_write(8'hE8, 8'h41, 1, 1'b0, "R2 strap 1 E8 refused");
        strap = 1'b0;

        // Stop inside a data byte (R10)
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hE8, 1'b0, a);
        send_byte(8'h50, 1'b0, a);
        exp_ptr = 8'h50;
        for (int i = 0; i < 4; i++) bus_bit(1'b0, 1'b0, a);
        bus_stop();
        tick(4);
        check(wr_cnt == w0, "R10 stop mid-byte", wr_cnt - w0, 0);
        do_read(1'b0, 8'h00, 1, "R10 pointer kept after stop");

        // Repeated start inside a data byte (R10)
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hE8, 1'b0, a);
        send_byte(8'h58, 1'b0, a);
        exp_ptr = 8'h58;
        for (int i = 0; i < 3; i++) bus_bit(1'b1, 1'b0, a);
        bus_start();
        send_byte(8'hE9, 1'b0, a);
        check(a, "R10 address after restart", int'(a), 1);
        recv_byte(1'b1, d);
        check(d == exp_mem[8'h58], "R10 restart read", int'(d), int'(exp_mem[8'h58]));
        exp_ptr = exp_ptr + 8'd1;
        bus_stop();
        tick(4);
        check(wr_cnt == w0, "R10 restart no strobe", wr_cnt - w0, 0);

        // SDA spike while SCL high is filtered (R12)
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hE8, 1'b0, a);
        send_byte(8'h60, 1'b0, a);
        send_byte(8'hFF, 1'b1, a);
        check(a, "R12 ack after spike", int'(a), 1);
        exp_mem[8'h60] = 8'hFF;
        exp_ptr = 8'h61;
        bus_stop();
        tick(4);
        check(wr_cnt - w0 == 1, "R12 one strobe", wr_cnt - w0, 1);
        check(bmem[8'h60] == 8'hFF, "R12 data intact", int'(bmem[8'h60]), 8'hFF);

        // Seeded random mix
        for (int k = 0; k < 20; k++) begin
            int op = int'($urandom % 3);
            if (op == 0) do_write(8'hE8, 8'($urandom), 1 + int'($urandom % 6), 1'b1, "R5 random write");
            else if (op == 1) do_read(1'b1, 8'($urandom), 1 + int'($urandom % 4), "R7 random read");
            else do_read(1'b0, 8'h00, 1 + int'($urandom % 3), "R7 random kept read");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(WATCHDOG);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule